// File: doc/BRIEF.md
# Clean-First Three-List Buffer Slot Manager

This block keeps the bookkeeping for a small, fixed pool of cache buffer slots in a storage controller. Each slot holds one logical page. The block sorts the slots by recency onto one of three lists. The clean list holds slots whose contents match the backing medium. The dirty list holds slots that were modified. The second-chance list holds modified slots that a background flush policy chose to keep for now. The lists are doubly linked through per-slot next and previous pointer arrays, with a head and a tail pointer for each list. Because of this, moving a slot to the front of a list takes a fixed number of cycles, however full the lists are.

A host request carries a two-bit operation and a logical page tag. A small tag CAM finds the slot that holds the page. On a miss, the manager takes a victim slot, always looking at the clean list first. If the victim holds modified data, the manager raises a flush request carrying the victim's old page tag and waits for an acknowledgement before it reuses the slot. Besides reads and writes, two housekeeping operations serve an external flush policy. One moves a dirty slot onto the second-chance list. The other marks a slot as clean after its data has been written back.

Each slot stores one byte of metadata: a 2-bit list code and a 6-bit saturating write count. Per-list occupancy counters are available as outputs.

Top module: `bufmgr_top`

## Requirements
- R1: After reset, every slot is on the clean list, with slot 0 at the head and slot N-1 at the tail. No tag is valid, every write count is 0, the occupancy outputs read N/0/0, and the request port is ready.
- R2: A request whose tag matches a valid slot reports a hit (`rspHit`=1) and that slot number. Any other tag reports a miss.
- R3: A read hit (op 0) moves the slot to the head of the list it is already on. Its list code and write count stay unchanged.
- R4: A write hit (op 1) on a clean slot moves it to the head of the dirty list, sets its list code to 1 and adds one to its write count.
- R5: A write hit on a slot that is on the dirty list (code 1) or the second-chance list (code 2) moves it to the head of that same list and adds one to its write count.
- R6: A read or write miss takes as victim the clean-list tail if the clean list is non-empty. Otherwise it takes the dirty-list tail, and otherwise the second-chance-list tail.
- R7: If the victim's list code is not 0, `flushReq` rises with the victim's old tag on `flushTag`. It stays high, with that tag held, until `flushDone`. `reqDone` comes only after `flushDone`, and `rspFlushed` is 1 for that request. A clean victim raises no flush.
- R8: A read miss leaves the victim at the clean-list head with code 0 and count 0. A write miss leaves it at the dirty-list head with code 1 and count 1. In both cases the slot then holds the new tag.
- R9: The write count saturates at 63 and never wraps.
- R10: The demote operation (op 2) on a hit slot with code 1 moves it to the second-chance-list head with count 1. On a clean slot, a second-chance slot or a missing tag it changes nothing.
- R11: The mark-clean operation (op 3) on a hit slot with code 1 or 2 moves it to the clean-list head with code 0 and its count unchanged. On a clean slot or a missing tag it changes nothing.
- R12: `occClean`, `occDirty` and `occSc` equal the sizes of the three lists at every request completion, and they sum to N whenever the manager is idle.
- R13: Only one request is in flight. `reqReady` is low from the cycle after acceptance until `reqDone` has been shown for one cycle, and `reqDone` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Manager idle and able to accept a request |
| reqOp | input | 2 | 0 read, 1 write, 2 demote, 3 mark clean |
| reqTag | input | TAG_W | Logical page tag |
| reqDone | output | 1 | One-cycle completion pulse; response fields valid |
| rspHit | output | 1 | Request hit a valid slot |
| rspSlot | output | $clog2(N) | Slot that was hit or that was used as victim |
| rspFlushed | output | 1 | The victim needed a flush before reuse |
| rspList | output | 2 | List code of the slot after the request |
| rspWcount | output | 6 | Write count of the slot after the request |
| flushReq | output | 1 | Flush of a dirty victim requested |
| flushTag | output | TAG_W | Page tag of the victim to flush |
| flushDone | input | 1 | Flush acknowledged |
| occClean | output | $clog2(N+1) | Clean-list occupancy |
| occDirty | output | $clog2(N+1) | Dirty-list occupancy |
| occSc | output | $clog2(N+1) | Second-chance-list occupancy |

## Verification
The bench keeps three ordered reference queues and slot metadata, and predicts every hit, slot, list code, count, flush and occupancy from them. A cold fill with read misses exposes the reset ordering. Read and write hits that follow reorder the lists, so later miss victims tell a true head insertion apart from a stale tail. Write misses that run the clean list dry force dirty-tail victims and flushes with varied acknowledgement delays. Demoting every dirty slot then forces a second-chance victim. Housekeeping operations are also issued on the wrong list and on absent tags, to show that they leave occupancy and metadata untouched. A long run of writes to one page reaches the count ceiling, and a pseudo-random mix of all four operations over a tag set wider than the pool covers interleavings.

// File: rtl/bufmgr_pkg.sv
`timescale 1ns/1ps
package bufmgr_pkg;
  localparam int WCNT_W = 6;
  localparam logic [WCNT_W-1:0] WCNT_MAX = '1;

  typedef enum logic [1:0] {
    LIST_CLEAN = 2'd0,
    LIST_DIRTY = 2'd1,
    LIST_SC    = 2'd2
  } list_e;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_DEMOTE = 2'd2,
    OP_CLEAN  = 2'd3
  } op_e;

  // one byte of metadata per slot
  typedef struct packed {
    list_e             lst;
    logic [WCNT_W-1:0] wcnt;
  } meta_t;

  typedef struct packed {
    logic capture;
    logic resolve;
    logic unlink;
    logic link;
  } strobe_t;

  typedef struct packed {
    logic hit;
    logic victimDirty;
    logic skip;
  } status_t;
endpackage

// File: rtl/bufmgr_dp.sv
`timescale 1ns/1ps
module bufmgr_dp
  import bufmgr_pkg::*;
#(
  parameter int N     = 8,
  parameter int TAG_W = 8,
  localparam int SW = $clog2(N),
  localparam int OW = $clog2(N + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  output status_t           status,
  input  logic [1:0]        reqOp,
  input  logic [TAG_W-1:0]  reqTag,
  output logic [TAG_W-1:0]  flushTag,
  output logic              rspHit,
  output logic [SW-1:0]     rspSlot,
  output logic              rspFlushed,
  output logic [1:0]        rspList,
  output logic [WCNT_W-1:0] rspWcount,
  output logic [OW-1:0]     occClean,
  output logic [OW-1:0]     occDirty,
  output logic [OW-1:0]     occSc
);
  localparam int PW = SW + 1;
  localparam logic [PW-1:0] NIL = PW'(N);

  // linked-list storage
  logic [PW-1:0]    nxt    [N];
  logic [PW-1:0]    prv    [N];
  logic [PW-1:0]    head   [3];
  logic [PW-1:0]    tail   [3];
  logic [OW-1:0]    occ    [3];
  meta_t            meta   [N];
  logic [TAG_W-1:0] tagArr [N];
  logic [N-1:0]     tagVld;

  // request context
  op_e               opQ;
  logic [TAG_W-1:0]  tagQ;
  logic [SW-1:0]     curSlot;
  list_e             tgtList;
  logic [WCNT_W-1:0] newCnt;
  logic              hitQ;
  logic              flushedQ;
  logic [TAG_W-1:0]  flushTagQ;

  // tag CAM
  logic [N-1:0] matchVec;
  for (genvar g = 0; g < N; g++) begin : gCam
    assign matchVec[g] = tagVld[g] && (tagArr[g] == tagQ);
  end

  logic          hitC;
  logic [SW-1:0] hitSlot;
  always_comb begin
    hitC    = 1'b0;
    hitSlot = '0;
    for (int i = 0; i < N; i++) begin
      if (matchVec[i]) begin
        hitC    = 1'b1;
        hitSlot = SW'(i);
      end
    end
  end

  // victim priority: clean tail, dirty tail, second-chance tail
  logic [PW-1:0] victPtr;
  logic [SW-1:0] victSlot;
  always_comb begin
    if (occ[LIST_CLEAN] != '0)      victPtr = tail[LIST_CLEAN];
    else if (occ[LIST_DIRTY] != '0) victPtr = tail[LIST_DIRTY];
    else                            victPtr = tail[LIST_SC];
  end
  assign victSlot = SW'(victPtr);

  meta_t hitMeta, victMeta;
  assign hitMeta  = meta[hitSlot];
  assign victMeta = meta[victSlot];

  logic              victDirty;
  logic              skipC;
  list_e             rsvList;
  logic [WCNT_W-1:0] rsvCnt;
  logic [WCNT_W-1:0] incCnt;
  logic              isRw;

  assign victDirty = (victMeta.lst != LIST_CLEAN);
  assign isRw      = (opQ == OP_READ) || (opQ == OP_WRITE);

  always_comb begin
    incCnt  = (hitMeta.wcnt == WCNT_MAX) ? hitMeta.wcnt : hitMeta.wcnt + 1'b1;
    rsvList = LIST_CLEAN;
    rsvCnt  = '0;
    skipC   = 1'b0;
    case (opQ)
      OP_READ: begin
        if (hitC) begin
          rsvList = hitMeta.lst;
          rsvCnt  = hitMeta.wcnt;
        end
      end
      OP_WRITE: begin
        if (hitC) begin
          rsvList = (hitMeta.lst == LIST_CLEAN) ? LIST_DIRTY : hitMeta.lst;
          rsvCnt  = incCnt;
        end else begin
          rsvList = LIST_DIRTY;
          rsvCnt  = WCNT_W'(1);
        end
      end
      OP_DEMOTE: begin
        rsvList = LIST_SC;
        rsvCnt  = WCNT_W'(1);
        skipC   = !(hitC && hitMeta.lst == LIST_DIRTY);
      end
      default: begin
        rsvList = LIST_CLEAN;
        rsvCnt  = hitMeta.wcnt;
        skipC   = !(hitC && hitMeta.lst != LIST_CLEAN);
      end
    endcase
  end

  assign status = '{hit: hitC, victimDirty: !hitC && victDirty, skip: skipC};

  // unlink and link operands
  list_e         uList;
  logic [PW-1:0] uPrev, uNext, lHead;
  assign uList = meta[curSlot].lst;
  assign uPrev = prv[curSlot];
  assign uNext = nxt[curSlot];
  assign lHead = head[tgtList];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) begin
        nxt[i]    <= (i == N - 1) ? NIL : PW'(i + 1);
        prv[i]    <= (i == 0) ? NIL : PW'(i - 1);
        meta[i]   <= '{lst: LIST_CLEAN, wcnt: '0};
        tagArr[i] <= '0;
      end
      tagVld            <= '0;
      head[LIST_CLEAN]  <= '0;
      tail[LIST_CLEAN]  <= PW'(N - 1);
      occ[LIST_CLEAN]   <= OW'(N);
      head[LIST_DIRTY]  <= NIL;
      tail[LIST_DIRTY]  <= NIL;
      occ[LIST_DIRTY]   <= '0;
      head[LIST_SC]     <= NIL;
      tail[LIST_SC]     <= NIL;
      occ[LIST_SC]      <= '0;
      opQ       <= OP_READ;
      tagQ      <= '0;
      curSlot   <= '0;
      tgtList   <= LIST_CLEAN;
      newCnt    <= '0;
      hitQ      <= 1'b0;
      flushedQ  <= 1'b0;
      flushTagQ <= '0;
    end else begin
      if (strobe.capture) begin
        opQ  <= op_e'(reqOp);
        tagQ <= reqTag;
      end
      if (strobe.resolve) begin
        curSlot   <= hitC ? hitSlot : victSlot;
        hitQ      <= hitC;
        flushedQ  <= !hitC && victDirty && isRw;
        flushTagQ <= tagArr[victSlot];
        tgtList   <= rsvList;
        newCnt    <= rsvCnt;
      end
      if (strobe.unlink) begin
        if (uPrev == NIL) head[uList] <= uNext;
        else              nxt[SW'(uPrev)] <= uNext;
        if (uNext == NIL) tail[uList] <= uPrev;
        else              prv[SW'(uNext)] <= uPrev;
        occ[uList] <= occ[uList] - 1'b1;
      end
      if (strobe.link) begin
        nxt[curSlot] <= lHead;
        prv[curSlot] <= NIL;
        if (lHead == NIL) tail[tgtList] <= PW'(curSlot);
        else              prv[SW'(lHead)] <= PW'(curSlot);
        head[tgtList]   <= PW'(curSlot);
        occ[tgtList]    <= occ[tgtList] + 1'b1;
        meta[curSlot]   <= '{lst: tgtList, wcnt: newCnt};
        tagArr[curSlot] <= tagQ;
        tagVld[curSlot] <= 1'b1;
      end
    end
  end

  assign flushTag   = flushTagQ;
  assign rspHit     = hitQ;
  assign rspSlot    = curSlot;
  assign rspFlushed = flushedQ;
  assign rspList    = meta[curSlot].lst;
  assign rspWcount  = meta[curSlot].wcnt;
  assign occClean   = occ[LIST_CLEAN];
  assign occDirty   = occ[LIST_DIRTY];
  assign occSc      = occ[LIST_SC];
endmodule

// File: rtl/bufmgr_ctrl.sv
`timescale 1ns/1ps
module bufmgr_ctrl
  import bufmgr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  status_t status,
  input  logic    flushDone,
  output logic    flushReq,
  output logic    reqDone,
  output strobe_t strobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_FLUSH, S_UNLINK, S_LINK, S_DONE
  } state_e;

  state_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    case (state)
      S_IDLE:   if (reqValid) stateNxt = S_LOOK;
      S_LOOK: begin
        if (status.skip)                            stateNxt = S_DONE;
        else if (!status.hit && status.victimDirty) stateNxt = S_FLUSH;
        else                                        stateNxt = S_UNLINK;
      end
      S_FLUSH:  if (flushDone) stateNxt = S_UNLINK;
      S_UNLINK: stateNxt = S_LINK;
      S_LINK:   stateNxt = S_DONE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  assign reqReady       = (state == S_IDLE);
  assign flushReq       = (state == S_FLUSH);
  assign reqDone        = (state == S_DONE);
  assign strobe.capture = (state == S_IDLE) && reqValid;
  assign strobe.resolve = (state == S_LOOK);
  assign strobe.unlink  = (state == S_UNLINK);
  assign strobe.link    = (state == S_LINK);
endmodule

// File: rtl/bufmgr_top.sv
`timescale 1ns/1ps
module bufmgr_top
  import bufmgr_pkg::*;
#(
  parameter int N     = 8,
  parameter int TAG_W = 8,
  localparam int SW = $clog2(N),
  localparam int OW = $clog2(N + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [1:0]       reqOp,
  input  logic [TAG_W-1:0] reqTag,
  output logic             reqDone,
  output logic             rspHit,
  output logic [SW-1:0]    rspSlot,
  output logic             rspFlushed,
  output logic [1:0]       rspList,
  output logic [5:0]       rspWcount,
  output logic             flushReq,
  output logic [TAG_W-1:0] flushTag,
  input  logic             flushDone,
  output logic [OW-1:0]    occClean,
  output logic [OW-1:0]    occDirty,
  output logic [OW-1:0]    occSc
);
  strobe_t strobe;
  status_t status;

  bufmgr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .status(status), .flushDone(flushDone), .flushReq(flushReq),
    .reqDone(reqDone), .strobe(strobe)
  );

  bufmgr_dp #(.N(N), .TAG_W(TAG_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .status(status),
    .reqOp(reqOp), .reqTag(reqTag), .flushTag(flushTag),
    .rspHit(rspHit), .rspSlot(rspSlot), .rspFlushed(rspFlushed),
    .rspList(rspList), .rspWcount(rspWcount),
    .occClean(occClean), .occDirty(occDirty), .occSc(occSc)
  );
endmodule

// File: rtl/bufmgr_chk.sv
`timescale 1ns/1ps
module bufmgr_chk #(
  parameter int N     = 8,
  parameter int TAG_W = 8,
  localparam int OW = $clog2(N + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [1:0]       reqOp,
  input logic             reqDone,
  input logic             rspHit,
  input logic [1:0]       rspList,
  input logic [5:0]       rspWcount,
  input logic             flushReq,
  input logic [TAG_W-1:0] flushTag,
  input logic             flushDone,
  input logic [OW-1:0]    occClean,
  input logic [OW-1:0]    occDirty,
  input logic [OW-1:0]    occSc
);
  logic [1:0] opCap;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     opCap <= 2'd0;
    else if (reqValid && reqReady) opCap <= reqOp;
  end

  a_r12_occ_sum: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (int'(occClean) + int'(occDirty) + int'(occSc) == N));

  a_r7_flush_hold: assert property (@(posedge clk) disable iff (!rstN)
    flushReq && !flushDone |=> flushReq && $stable(flushTag));

  a_r7_no_done_in_flush: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |-> !reqDone);

  a_r13_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  a_r8_write_miss: assert property (@(posedge clk) disable iff (!rstN)
    reqDone && !rspHit && opCap == 2'd1 |-> rspList == 2'd1 && rspWcount == 6'd1);

  a_r8_read_miss: assert property (@(posedge clk) disable iff (!rstN)
    reqDone && !rspHit && opCap == 2'd0 |-> rspList == 2'd0 && rspWcount == 6'd0);

  a_r4_write_hit_dirty: assert property (@(posedge clk) disable iff (!rstN)
    reqDone && rspHit && opCap == 2'd1 |-> rspList != 2'd0 && rspWcount != 6'd0);
endmodule

bind bufmgr_top bufmgr_chk #(.N(N), .TAG_W(TAG_W)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqOp(reqOp), .reqDone(reqDone), .rspHit(rspHit), .rspList(rspList),
  .rspWcount(rspWcount), .flushReq(flushReq), .flushTag(flushTag),
  .flushDone(flushDone), .occClean(occClean), .occDirty(occDirty), .occSc(occSc)
);

// File: tb/sim_bufmgr_top.sv
`timescale 1ns/1ps
module sim_bufmgr_top;
  localparam int N = 8;
  localparam int TAG_W = 8;
  localparam int SW = $clog2(N);
  localparam int OW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic             reqValid, reqReady, reqDone, rspHit, rspFlushed;
  logic             flushReq, flushDone;
  logic [1:0]       reqOp, rspList;
  logic [TAG_W-1:0] reqTag, flushTag;
  logic [SW-1:0]    rspSlot;
  logic [5:0]       rspWcount;
  logic [OW-1:0]    occClean, occDirty, occSc;

  bufmgr_top #(.N(N), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqTag(reqTag), .reqDone(reqDone), .rspHit(rspHit),
    .rspSlot(rspSlot), .rspFlushed(rspFlushed), .rspList(rspList),
    .rspWcount(rspWcount), .flushReq(flushReq), .flushTag(flushTag),
    .flushDone(flushDone), .occClean(occClean), .occDirty(occDirty), .occSc(occSc)
  );

  int nChecks = 0;
  int nFails  = 0;

  // reference model: index 0 is the head, last entry is the tail
  int qC[$];
  int qD[$];
  int qS[$];
  int mTag[N];
  bit mVld[N];
  int mList[N];
  int mCnt[N];

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void qDel(input int l, input int s);
    int idx = -1;
    case (l)
      0: begin foreach (qC[i]) if (qC[i] == s) idx = i; if (idx >= 0) qC.delete(idx); end
      1: begin foreach (qD[i]) if (qD[i] == s) idx = i; if (idx >= 0) qD.delete(idx); end
      default: begin foreach (qS[i]) if (qS[i] == s) idx = i; if (idx >= 0) qS.delete(idx); end
    endcase
  endfunction

  function automatic void qPush(input int l, input int s);
    case (l)
      0: qC.push_front(s);
      1: qD.push_front(s);
      default: qS.push_front(s);
    endcase
  endfunction

  task automatic doReq(input int op, input int tag, input int fdly, input string req);
    int hs = -1;
    int expSlot = 0;
    bit expHit, expFl = 0, mgmtMiss = 0, seenFl = 0, busyBad = 0;
    int expFTag = 0, gotFTag = 0, fc = 0, waitCnt = 0, v;
    for (int s = 0; s < N; s++) if (mVld[s] && mTag[s] == tag) hs = s;
    expHit = (hs >= 0);
    if (expHit) begin
      expSlot = hs;
      case (op)
        0: begin qDel(mList[hs], hs); qPush(mList[hs], hs); end
        1: begin
          qDel(mList[hs], hs);
          if (mList[hs] == 0) mList[hs] = 1;
          qPush(mList[hs], hs);
          if (mCnt[hs] < 63) mCnt[hs]++;
        end
        2: if (mList[hs] == 1) begin
          qDel(1, hs); qPush(2, hs); mList[hs] = 2; mCnt[hs] = 1;
        end
        default: if (mList[hs] != 0) begin
          qDel(mList[hs], hs); qPush(0, hs); mList[hs] = 0;
        end
      endcase
    end else if (op < 2) begin
      v = (qC.size() > 0) ? qC[$] : ((qD.size() > 0) ? qD[$] : qS[$]);
      expSlot = v;
      expFl   = (mList[v] != 0);
      expFTag = mTag[v];
      qDel(mList[v], v);
      mTag[v] = tag;
      mVld[v] = 1'b1;
      mList[v] = op;
      mCnt[v]  = op;
      qPush(op, v);
    end else begin
      mgmtMiss = 1'b1;
    end

    @(negedge clk);
    reqValid = 1'b1;
    reqOp    = op[1:0];
    reqTag   = tag[TAG_W-1:0];
    @(negedge clk);
    reqValid = 1'b0;
    while (!reqDone && waitCnt < 200) begin
      if (reqReady) busyBad = 1'b1;
      flushDone = 1'b0;
      if (flushReq) begin
        if (!seenFl) gotFTag = int'(flushTag);
        seenFl = 1'b1;
        fc++;
        if (fc > fdly) flushDone = 1'b1;
      end
      @(negedge clk);
      waitCnt++;
    end
    flushDone = 1'b0;
    if (!reqDone) begin
      chkEq("R13", "request completion", 0, 1);
      return;
    end
    chkEq("R2", "hit", int'(rspHit), int'(expHit));
    if (!mgmtMiss) begin
      chkEq(expHit ? req : "R6", "slot", int'(rspSlot), expSlot);
      chkEq(req, "list code", int'(rspList), mList[expSlot]);
      chkEq(req, "write count", int'(rspWcount), mCnt[expSlot]);
    end
    chkEq("R7", "flush seen", int'(seenFl), int'(expFl));
    chkEq("R7", "flushed flag", int'(rspFlushed), int'(expFl));
    if (expFl) chkEq("R7", "flush tag", gotFTag, expFTag);
    chkEq("R12", "clean occupancy", int'(occClean), qC.size());
    chkEq("R12", "dirty occupancy", int'(occDirty), qD.size());
    chkEq("R12", "second-chance occupancy", int'(occSc), qS.size());
    chkEq("R13", "ready low while busy", int'(busyBad), 0);
    @(negedge clk);
    chkEq("R13", "ready after done", int'(reqReady), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R13 watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int seed = 12345;
    int op;
    reqValid = 1'b0;
    reqOp = 2'd0;
    reqTag = '0;
    flushDone = 1'b0;
    for (int s = 0; s < N; s++) begin
      qC.push_back(s);
      mVld[s] = 1'b0; mList[s] = 0; mCnt[s] = 0; mTag[s] = 0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1", "ready", int'(reqReady), 1);
    chkEq("R1", "clean occupancy", int'(occClean), N);
    chkEq("R1", "dirty occupancy", int'(occDirty), 0);
    chkEq("R1", "second-chance occupancy", int'(occSc), 0);
    chkEq("R1", "flush idle", int'(flushReq), 0);
    chkEq("R1", "done idle", int'(reqDone), 0);

    // cold fill: victims come out N-1 down to 0 (R1, R8)
    for (int t = 0; t < N; t++) doReq(0, 16 + t, 0, "R8");
    doReq(0, 16, 0, "R3");
    doReq(0, 19, 0, "R3");
    doReq(1, 17, 0, "R4");
    doReq(1, 20, 0, "R4");
    doReq(1, 17, 0, "R5");
    doReq(0, 40, 0, "R6");
    doReq(1, 41, 0, "R8");
    // demote cases (R10)
    doReq(2, 17, 0, "R10");
    doReq(2, 16, 0, "R10");
    doReq(2, 99, 0, "R10");
    doReq(1, 17, 0, "R5");
    doReq(2, 17, 0, "R10");
    doReq(0, 17, 0, "R3");
    // mark-clean cases (R11)
    doReq(3, 20, 0, "R11");
    doReq(3, 17, 0, "R11");
    doReq(3, 16, 0, "R11");
    doReq(3, 98, 0, "R11");
    // drain clean list, then dirty victims with flushes (R7)
    for (int t = 0; t < N; t++) doReq(1, 50 + t, t % 4, "R7");
    doReq(1, 60, 2, "R6");
    // move every dirty slot to second chance, then miss (R6)
    for (int t = 50; t <= 60; t++) doReq(2, t, 0, "R10");
    doReq(0, 70, 1, "R6");
    doReq(1, 71, 3, "R6");
    // saturation (R9)
    for (int k = 0; k < 70; k++) doReq(1, 70, 0, "R9");
    // pseudo-random mix
    for (int k = 0; k < 400; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      op = (seed >> 3) % 4;
      doReq(op, 100 + ((seed >> 7) % 12), (seed >> 12) % 4,
            op == 0 ? "R3" : (op == 1 ? "R5" : (op == 2 ? "R10" : "R11")));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule